// File: doc/BRIEF.md
# Auto-Programming Non-Volatile Word Store Controller

This controller fronts a small word-addressed non-volatile array, modelled here as an internal register array. Two slave windows share one simple request bus, and `bus_data_win` selects between them. The control window holds the mode, divider, power and status registers. The data window maps the array itself, one 32-bit word per 4-byte step. Software selects auto-program mode, programs a clock divider, and powers the array up. After the wake-up delay has elapsed, each aligned word it writes to the data window starts a timed erase/program cycle on its own.

A free-running divider produces one tick every (divider value + 1) bus clocks. Software sets the divider so that the tick rate falls between 800 kHz and 1600 kHz, with 1.5 MHz as the usual target. The program cycle and the wake-up delay are both counted in these ticks. By default the program cycle is 4500 ticks (3 ms) and the wake-up delay is 150 ticks (100 us). When a cycle finishes, the word is committed and a sticky completion bit is raised. That bit drives the interrupt output until software writes one to clear it.

The top 128-byte page of the array carries initialisation data and can never be written. A data write that cannot be honoured is dropped, and the controller answers it with a one-cycle reject pulse.

Top module: `nvc_ctrl`

## Requirements
- R1: After reset the interrupt output is 0 and the reject pulse is 0. Register reads return: power register (0x018) = 1, mode register (0x00C) = 0, divider register (0x014) = 0, status register (0xFE0) = 0. Data-window reads return 0.
- R2: Control-window reads return the register contents. Mode is bit 0 at 0x00C, the divider value is the low DIV_W bits at 0x014, power-off is bit 0 at 0x018, and program-done is bit 2 at 0xFE0. Any other offset reads 0.
- R3: The divider ticks once every (divider value + 1) clocks. With divider D and PROG_TICKS P, the done bit is still 0 exactly (P-1)(D+1) clocks after the edge that accepts a write, and is 1 by P(D+1) clocks after that edge.
- R4: Writing 0 to the power register while it holds 1 starts a wake-up delay of WAKE_TICKS ticks. Until that delay ends, data writes are rejected and data reads return 0. Writing 1 powers the array down at once.
- R5: An accepted write stores its word when its program cycle completes. Completion sets status bit 2, and the interrupt output is high while that bit is 1.
- R6: Writing a word with bit 2 set to 0xFE8 clears the done bit. Writing without bit 2 has no effect. When a clear and a completion fall on the same edge, the bit ends set.
- R7: A data write is dropped, and wr_reject is high for the one cycle after it, in any of these cases: a program cycle is running; the array is off or still waking; the mode bit is 0; the byte address is not a multiple of 4; or the address lies in the last page or beyond. A dropped write leaves the array and the done bit unchanged.
- R8: A read request presents its result on bus_rdata from the next clock edge. A data-window read returns the stored word when the array is awake, and 0 otherwise.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bus clock |
| rst_n | input | 1 | Active-low synchronous reset |
| bus_req | input | 1 | Access request, one cycle per access |
| bus_data_win | input | 1 | 1 selects the data window, 0 the control window |
| bus_we | input | 1 | 1 write, 0 read |
| bus_addr | input | ADDR_W | Byte address within the selected window |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data, valid the cycle after a read request |
| wr_reject | output | 1 | One-cycle pulse for a dropped data write |
| irq | output | 1 | High while the program-done bit is set |

## Verification
The completion of a program cycle and a software clear of the done bit can land on the same clock edge. This is provoked by starting a program cycle and then issuing a clear write on every consecutive clock. The design must show the interrupt high just after the one edge where the completion and a clear coincide. It must then show it low after the next clear. A clear issued earlier, with no completion on the same edge, must leave it low, so the test also shows that the set wins over the clear and is not lost.

// File: rtl/nvc_pkg.sv
package nvc_pkg;
   // Control-window byte offsets (software decodes these)
   localparam int unsigned OFS_MODE  = 'h00C;
   localparam int unsigned OFS_DIV   = 'h014;
   localparam int unsigned OFS_PWR   = 'h018;
   localparam int unsigned OFS_STAT  = 'hFE0;
   localparam int unsigned OFS_CLR   = 'hFE8;
   // Program-done bit position in status and clear registers
   localparam int unsigned DONE_BIT  = 2;
   localparam int unsigned WORD_BITS = 32;
endpackage

// File: rtl/nvc_tick_gen.sv
module nvc_tick_gen #(
   parameter int DIV_W = 8
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic [DIV_W-1:0] div_val,
   output logic             tick
);
   logic [DIV_W-1:0] cnt;

   // tick after div_val+1 clocks; a shrunk divider wraps at once
   assign tick = (cnt >= div_val);

   always_ff @(posedge clk) begin
      if (!rst_n)    cnt <= '0;
      else if (tick) cnt <= '0;
      else           cnt <= cnt + 1'b1;
   end
endmodule

// File: rtl/nvc_countdown.sv
module nvc_countdown #(
   parameter int LOAD_VAL = 4,
   localparam int CNT_W   = $clog2(LOAD_VAL + 1)
) (
   input  logic clk,
   input  logic rst_n,
   input  logic load,
   input  logic clear,
   input  logic tick,
   output logic active,
   output logic expire
);
   logic [CNT_W-1:0] cnt;

   generate
      if (LOAD_VAL < 1) begin : g_bad_load
         $error("nvc_countdown: LOAD_VAL must be at least 1");
      end
   endgenerate

   always_ff @(posedge clk) begin
      if (!rst_n)                  cnt <= '0;
      else if (clear)              cnt <= '0;
      else if (load)               cnt <= CNT_W'(LOAD_VAL);
      else if (tick && cnt != '0)  cnt <= cnt - 1'b1;
   end

   assign active = (cnt != '0);
   assign expire = tick && (cnt == CNT_W'(1)) && !load && !clear;
endmodule

// File: rtl/nvc_array.sv
module nvc_array #(
   parameter int DEPTH  = 256,
   parameter int WIDTH  = 32,
   localparam int IDX_W = $clog2(DEPTH)
) (
   input  logic             clk,
   input  logic             we,
   input  logic [IDX_W-1:0] widx,
   input  logic [WIDTH-1:0] wdata,
   input  logic [IDX_W-1:0] ridx,
   output logic [WIDTH-1:0] rdata
);
   logic [WIDTH-1:0] cells [DEPTH];

   always_ff @(posedge clk) begin
      if (we) cells[widx] <= wdata;
   end

   assign rdata = cells[ridx];
endmodule

// File: rtl/nvc_ctrl.sv
module nvc_ctrl
   import nvc_pkg::*;
#(
   parameter int ADDR_W      = 12,
   parameter int DEPTH_WORDS = 256,
   parameter int PAGE_BYTES  = 128,
   parameter int DIV_W       = 8,
   parameter int PROG_TICKS  = 4500,
   parameter int WAKE_TICKS  = 150
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              bus_req,
   input  logic              bus_data_win,
   input  logic              bus_we,
   input  logic [ADDR_W-1:0] bus_addr,
   input  logic [31:0]       bus_wdata,
   output logic [31:0]       bus_rdata,
   output logic              wr_reject,
   output logic              irq
);
   localparam int MEM_BYTES = DEPTH_WORDS * 4;
   localparam int IDX_W     = $clog2(DEPTH_WORDS);
   localparam logic [ADDR_W-1:0] PROT_BASE = ADDR_W'(MEM_BYTES - PAGE_BYTES);
   localparam logic [ADDR_W-1:0] MEM_END   = ADDR_W'(MEM_BYTES);

   generate
      if (ADDR_W < 12 || ADDR_W < $clog2(MEM_BYTES) + 1) begin : g_bad_aw
         $error("nvc_ctrl: ADDR_W too narrow for control or data window");
      end
      if (PAGE_BYTES % 4 != 0 || MEM_BYTES % PAGE_BYTES != 0) begin : g_bad_page
         $error("nvc_ctrl: page size must be whole words and divide the array");
      end
      if (MEM_BYTES < 2 * PAGE_BYTES) begin : g_bad_depth
         $error("nvc_ctrl: array needs at least one writable page");
      end
      if ((1 << IDX_W) != DEPTH_WORDS) begin : g_bad_pow2
         $error("nvc_ctrl: DEPTH_WORDS must be a power of two");
      end
   endgenerate

   // ---------------- register state ----------------
   logic              mode_auto;
   logic [DIV_W-1:0]  div_val;
   logic              pwr_off;
   logic              done_q;
   logic [IDX_W-1:0]  pend_idx;
   logic [31:0]       pend_word;

   // ---------------- decode ----------------
   logic ctl_wr, dat_wr, rd_req;
   logic hit_mode, hit_div, hit_pwr, hit_stat, hit_clr;
   assign ctl_wr = bus_req &&  bus_we && !bus_data_win;
   assign dat_wr = bus_req &&  bus_we &&  bus_data_win;
   assign rd_req = bus_req && !bus_we;

   assign hit_mode = (bus_addr == ADDR_W'(OFS_MODE));
   assign hit_div  = (bus_addr == ADDR_W'(OFS_DIV));
   assign hit_pwr  = (bus_addr == ADDR_W'(OFS_PWR));
   assign hit_stat = (bus_addr == ADDR_W'(OFS_STAT));
   assign hit_clr  = (bus_addr == ADDR_W'(OFS_CLR));

   // ---------------- tick and timers ----------------
   logic tick;
   logic wake_busy, wake_end_unused;
   logic prog_busy, prog_done;
   logic awake, dat_ok, prog_start;
   logic wake_load, wake_clear;

   nvc_tick_gen #(.DIV_W(DIV_W)) u_tick (
      .clk(clk), .rst_n(rst_n), .div_val(div_val), .tick(tick)
   );

   assign wake_load  = ctl_wr && hit_pwr && !bus_wdata[0] && pwr_off;
   assign wake_clear = ctl_wr && hit_pwr &&  bus_wdata[0];

   nvc_countdown #(.LOAD_VAL(WAKE_TICKS)) u_wake (
      .clk(clk), .rst_n(rst_n), .load(wake_load), .clear(wake_clear),
      .tick(tick), .active(wake_busy), .expire(wake_end_unused)
   );

   assign awake  = !pwr_off && !wake_busy;
   assign dat_ok = mode_auto && awake && !prog_busy
                   && (bus_addr[1:0] == 2'b00) && (bus_addr < PROT_BASE);
   assign prog_start = dat_wr && dat_ok;

   nvc_countdown #(.LOAD_VAL(PROG_TICKS)) u_prog (
      .clk(clk), .rst_n(rst_n), .load(prog_start), .clear(1'b0),
      .tick(tick), .active(prog_busy), .expire(prog_done)
   );

   // ---------------- storage ----------------
   logic [31:0] arr_rd;
   nvc_array #(.DEPTH(DEPTH_WORDS), .WIDTH(WORD_BITS)) u_arr (
      .clk(clk), .we(prog_done), .widx(pend_idx), .wdata(pend_word),
      .ridx(bus_addr[IDX_W+1:2]), .rdata(arr_rd)
   );

   // ---------------- register writes ----------------
   always_ff @(posedge clk) begin
      if (!rst_n) begin
         mode_auto <= 1'b0;
         div_val   <= '0;
         pwr_off   <= 1'b1;
         done_q    <= 1'b0;
         pend_idx  <= '0;
         pend_word <= '0;
         wr_reject <= 1'b0;
      end else begin
         if (ctl_wr && hit_mode) mode_auto <= bus_wdata[0];
         if (ctl_wr && hit_div)  div_val   <= bus_wdata[DIV_W-1:0];
         if (ctl_wr && hit_pwr)  pwr_off   <= bus_wdata[0];
         // completion outranks a clear on the same edge
         if (prog_done)                                   done_q <= 1'b1;
         else if (ctl_wr && hit_clr && bus_wdata[DONE_BIT]) done_q <= 1'b0;
         if (prog_start) begin
            pend_idx  <= bus_addr[IDX_W+1:2];
            pend_word <= bus_wdata;
         end
         wr_reject <= dat_wr && !dat_ok;
      end
   end

   // ---------------- read path ----------------
   logic [31:0] ctl_rd;
   always_comb begin
      ctl_rd = '0;
      if (hit_mode)      ctl_rd[0] = mode_auto;
      else if (hit_div)  ctl_rd[DIV_W-1:0] = div_val;
      else if (hit_pwr)  ctl_rd[0] = pwr_off;
      else if (hit_stat) ctl_rd[DONE_BIT] = done_q;
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         bus_rdata <= '0;
      end else if (rd_req) begin
         if (!bus_data_win)                     bus_rdata <= ctl_rd;
         else if (awake && bus_addr < MEM_END)  bus_rdata <= arr_rd;
         else                                   bus_rdata <= '0;
      end
   end

   assign irq = done_q;
endmodule

// File: rtl/nvc_checker.sv
module nvc_checker
   import nvc_pkg::*;
#(
   parameter int ADDR_W = 12
) (
   input logic              clk,
   input logic              rst_n,
   input logic              bus_req,
   input logic              bus_data_win,
   input logic              bus_we,
   input logic [ADDR_W-1:0] bus_addr,
   input logic [31:0]       bus_wdata,
   input logic [31:0]       bus_rdata,
   input logic              wr_reject,
   input logic              irq,
   input logic              prog_busy,
   input logic              prog_done,
   input logic              pwr_off
);
   logic clr_hit, dwr, drd;
   assign clr_hit = bus_req && bus_we && !bus_data_win
                    && bus_addr == ADDR_W'(OFS_CLR) && bus_wdata[DONE_BIT];
   assign dwr = bus_req && bus_we && bus_data_win;
   assign drd = bus_req && !bus_we && bus_data_win;

   a_r6_irq_sticky: assert property (@(posedge clk) disable iff (!rst_n)
      (irq && !clr_hit) |=> irq);
   a_r6_clear_drops_irq: assert property (@(posedge clk) disable iff (!rst_n)
      (clr_hit && !prog_done) |=> !irq);
   a_r5_done_raises_irq: assert property (@(posedge clk) disable iff (!rst_n)
      prog_done |=> irq);
   a_r3_done_within_busy: assert property (@(posedge clk) disable iff (!rst_n)
      prog_done |-> prog_busy);
   a_r7_busy_rejects: assert property (@(posedge clk) disable iff (!rst_n)
      (dwr && prog_busy) |=> wr_reject);
   a_r4_off_rejects: assert property (@(posedge clk) disable iff (!rst_n)
      (dwr && pwr_off) |=> wr_reject);
   a_r8_off_reads_zero: assert property (@(posedge clk) disable iff (!rst_n)
      (drd && pwr_off) |=> (bus_rdata == 32'h0));
endmodule

bind nvc_ctrl nvc_checker #(.ADDR_W(ADDR_W)) u_chk (.*);

// File: tb/sim_nvc_ctrl.sv
`timescale 1ns/1ps
module sim_nvc_ctrl;
   localparam int P = 6;
   localparam int W = 4;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        bus_req = 1'b0;
   logic        bus_data_win = 1'b0;
   logic        bus_we = 1'b0;
   logic [11:0] bus_addr = '0;
   logic [31:0] bus_wdata = '0;
   logic [31:0] bus_rdata;
   logic        wr_reject;
   logic        irq;

   int checks = 0;
   int errors = 0;

   always #2 clk = ~clk;

   nvc_ctrl #(.PROG_TICKS(P), .WAKE_TICKS(W)) u0 (
      .clk(clk), .rst_n(rst_n), .bus_req(bus_req), .bus_data_win(bus_data_win),
      .bus_we(bus_we), .bus_addr(bus_addr), .bus_wdata(bus_wdata),
      .bus_rdata(bus_rdata), .wr_reject(wr_reject), .irq(irq)
   );

   // {byte address, word}
   localparam logic [43:0] VEC [6] = '{
      {12'h000, 32'hDEADBEEF}, {12'h004, 32'h01234567},
      {12'h0FC, 32'hA5A55A5A}, {12'h100, 32'hFFFFFFFF},
      {12'h200, 32'h80000001}, {12'h37C, 32'hC0FFEE11}
   };

   task automatic chk(input bit ok, input string req, input logic [31:0] act,
                      input logic [31:0] exp);
      checks++;
      if (!ok) begin
         errors++;
         $display("FAIL %s: actual %h expected %h", req, act, exp);
      end
   endtask

   // all bus tasks are entered at a falling edge and return at one
   task automatic wr(input logic win, input logic [11:0] a, input logic [31:0] d);
      bus_req = 1'b1; bus_we = 1'b1; bus_data_win = win; bus_addr = a; bus_wdata = d;
      @(negedge clk);
      bus_req = 1'b0; bus_we = 1'b0;
   endtask

   task automatic rd(input logic win, input logic [11:0] a, output logic [31:0] d);
      bus_req = 1'b1; bus_we = 1'b0; bus_data_win = win; bus_addr = a;
      @(negedge clk);
      bus_req = 1'b0;
      d = bus_rdata;
   endtask

   task automatic prog_timed(input logic [11:0] a, input logic [31:0] d, input int dv);
      wr(1'b1, a, d);
      chk(wr_reject == 1'b0, "R5 accept", 32'(wr_reject), 0);
      repeat ((P - 1) * (dv + 1)) @(negedge clk);
      chk(irq == 1'b0, "R3 not early", 32'(irq), 0);
      repeat (dv + 1) @(negedge clk);
      chk(irq == 1'b1, "R3 done by deadline", 32'(irq), 1);
   endtask

   task automatic clear_done();
      wr(1'b0, 12'hFE8, 32'h4);
      chk(irq == 1'b0, "R6 clear", 32'(irq), 0);
   endtask

   initial begin
      repeat (200000) @(posedge clk);
      errors++;
      $display("FAIL watchdog: actual timeout expected finish");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   end

   initial begin
      logic [31:0] v;
      bit seen;
      repeat (3) @(negedge clk);
      rst_n = 1'b1;

      // R1 reset state
      chk(irq == 1'b0, "R1 irq", 32'(irq), 0);
      chk(wr_reject == 1'b0, "R1 reject", 32'(wr_reject), 0);
      rd(1'b0, 12'h018, v); chk(v == 1, "R1 power", v, 1);
      rd(1'b0, 12'h00C, v); chk(v == 0, "R1 mode", v, 0);
      rd(1'b0, 12'h014, v); chk(v == 0, "R1 divider", v, 0);
      rd(1'b0, 12'hFE0, v); chk(v == 0, "R1 status", v, 0);
      rd(1'b1, 12'h000, v); chk(v == 0, "R1 data off", v, 0);

      // R7 write while off and mode clear
      wr(1'b1, 12'h000, 32'h1);
      chk(wr_reject == 1'b1, "R7 off reject", 32'(wr_reject), 1);
      @(negedge clk);
      chk(wr_reject == 1'b0, "R7 pulse one cycle", 32'(wr_reject), 0);

      // R2 registers
      wr(1'b0, 12'h00C, 32'h1);
      wr(1'b0, 12'h014, 32'h1);
      rd(1'b0, 12'h00C, v); chk(v == 1, "R2 mode", v, 1);
      rd(1'b0, 12'h014, v); chk(v == 1, "R2 divider", v, 1);
      rd(1'b0, 12'h010, v); chk(v == 0, "R2 unmapped", v, 0);

      // R4 wake-up delay, divider 1
      wr(1'b0, 12'h018, 32'h0);
      rd(1'b1, 12'h000, v); chk(v == 0, "R4 read while waking", v, 0);
      repeat ((W - 1) * 2 - 1) @(negedge clk);
      wr(1'b1, 12'h040, 32'h5555AAAA);
      chk(wr_reject == 1'b1, "R4 early write", 32'(wr_reject), 1);
      repeat (2) @(negedge clk);
      wr(1'b1, 12'h040, 32'h5555AAAA);
      chk(wr_reject == 1'b0, "R4 awake write", 32'(wr_reject), 0);
      repeat (P * 2 + 1) @(negedge clk);
      chk(irq == 1'b1, "R5 irq after program", 32'(irq), 1);
      rd(1'b0, 12'hFE0, v); chk(v == 32'h4, "R5 status bit2", v, 4);
      clear_done();
      rd(1'b1, 12'h040, v); chk(v == 32'h5555AAAA, "R5 readback", v, 32'h5555AAAA);

      // table walk: R3 R5 R6 R8
      for (int i = 0; i < 6; i++) begin
         prog_timed(VEC[i][43:32], VEC[i][31:0], 1);
         clear_done();
         rd(1'b1, VEC[i][43:32], v);
         chk(v == VEC[i][31:0], "R8 table readback", v, VEC[i][31:0]);
      end

      // R6 clear without bit 2 has no effect
      prog_timed(12'h008, 32'h0BADF00D, 1);
      wr(1'b0, 12'hFE8, 32'h3);
      chk(irq == 1'b1, "R6 no-bit2 clear", 32'(irq), 1);
      clear_done();

      // R7 busy rejection
      wr(1'b1, 12'h010, 32'h11112222);
      wr(1'b1, 12'h004, 32'h99999999);
      chk(wr_reject == 1'b1, "R7 busy reject", 32'(wr_reject), 1);
      repeat (P * 2 + 1) @(negedge clk);
      clear_done();
      rd(1'b1, 12'h004, v); chk(v == 32'h01234567, "R7 busy left array", v, 32'h01234567);
      rd(1'b1, 12'h010, v); chk(v == 32'h11112222, "R7 first write kept", v, 32'h11112222);

      // R7 last page, misaligned, mode clear
      wr(1'b1, 12'h380, 32'h77777777);
      chk(wr_reject == 1'b1, "R7 last page", 32'(wr_reject), 1);
      wr(1'b1, 12'h102, 32'h77777777);
      chk(wr_reject == 1'b1, "R7 misaligned", 32'(wr_reject), 1);
      wr(1'b0, 12'h00C, 32'h0);
      wr(1'b1, 12'h100, 32'h77777777);
      chk(wr_reject == 1'b1, "R7 mode clear", 32'(wr_reject), 1);
      repeat (P * 2 + 2) @(negedge clk);
      chk(irq == 1'b0, "R7 no completion", 32'(irq), 0);
      rd(1'b1, 12'h100, v); chk(v == 32'hFFFFFFFF, "R7 array kept", v, 32'hFFFFFFFF);
      wr(1'b0, 12'h00C, 32'h1);

      // R3 slower divider
      wr(1'b0, 12'h014, 32'h3);
      prog_timed(12'h044, 32'h3C3C3C3C, 3);
      clear_done();
      rd(1'b1, 12'h044, v); chk(v == 32'h3C3C3C3C, "R3 div3 readback", v, 32'h3C3C3C3C);
      wr(1'b0, 12'h014, 32'h1);

      // R6 clear on every cycle while the cycle completes: set must win
      wr(1'b1, 12'h020, 32'hCAFE0020);
      seen = 1'b0;
      for (int i = 0; i < P * 2 + 4; i++) begin
         wr(1'b0, 12'hFE8, 32'h4);
         if (irq) begin seen = 1'b1; break; end
      end
      chk(seen, "R6 set wins same edge", 32'(seen), 1);
      clear_done();

      // R4/R8 power down
      wr(1'b0, 12'h018, 32'h1);
      rd(1'b1, 12'h000, v); chk(v == 0, "R8 off read zero", v, 0);
      rd(1'b0, 12'h018, v); chk(v == 1, "R4 power readback", v, 1);

      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   end
endmodule